// File: doc/BRIEF.md
# Timing-Pulse Subsequence Sequencer

This block paces the execution of each instruction of a small accumulator machine. Every instruction is carried out as a chain of one or more subsequences. Each subsequence lasts twelve timing pulses, TP1 to TP12. The sequencer presents the running subsequence as a 4-bit identifier and the current pulse as a one-hot 12-bit vector. A separate control decoder, which is not part of this block, combines the two to raise up to five control pulses per timing pulse.

At the end of an instruction the sequencer loads its operation register and its operand-address register from the prefetch buffer word. It then chooses the first subsequence of the new instruction. A transfer instruction aimed at a reserved address acts as an extend prefix. It causes the next instruction's 3-bit operation field to be read as an extended operation: multiply, divide, subtract, or an unassigned extended code. Multiply is the only multi-subsequence operation. It runs one initial subsequence, then a step subsequence six times over, then a closing subsequence. Everything advances only on cycles where the clock enable is high.

Top module: `tp_sequencer`

## Requirements
- R1: During and right after synchronous reset: tp = 12'b1 (TP1), subseq = 0, seq_reg = 0, addr_reg = 0, eoi = 0, and the extend prefix is inactive.
- R2: tp is always one-hot. On each enabled cycle it moves from bit k to bit k+1. From bit 11 (TP12) it returns to bit 0 (TP1).
- R3: On a cycle with ce low, tp, subseq, seq_reg, addr_reg and eoi keep their values, even during TP12 of the last subsequence.
- R4: On the enabled edge that ends the last subsequence, seq_reg takes pbuf[14:12] and addr_reg takes pbuf[11:0]. On every other edge they hold.
- R5: Without the extend prefix, every operation code 0..7 runs one subsequence whose identifier equals the code.
- R6: The extend prefix is an instruction with seq_reg = 0 and addr_reg = EXT_ADDR (default 6) that is not itself extended. The instruction loaded at its end is extended.
- R7: Extended code 0 (multiply) runs subsequence 8 once, then subsequence 11 exactly six times, then subsequence 12. That is 96 enabled cycles in total.
- R8: Extended code 1 runs one subsequence with identifier 9. Extended code 2 runs one with identifier 10. Extended codes 3..7 each run one with identifier 13.
- R9: The extend prefix is cleared at the end of the extended instruction. An extended instruction whose word is 0 / EXT_ADDR does not arm a further prefix.
- R10: eoi is high exactly while tp is TP12 within the last subsequence of an instruction. It is low at every other time, including TP12 of non-final multiply subsequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; the sequencer advances only while high |
| pbuf | input | 15 | Prefetch buffer word: operation [14:12], address [11:0] |
| seq_reg | output | 3 | Operation field of the executing instruction |
| addr_reg | output | 12 | Address field of the executing instruction |
| subseq | output | 4 | Identifier of the running subsequence |
| tp | output | 12 | One-hot timing pulse, bit 0 = TP1 |
| eoi | output | 1 | End-of-instruction strobe |

## Verification
Three things happen on the same enabled edge at the end of an instruction: the instruction load, the extend-prefix update and the choice of the first subsequence. A clock-enable gap can also land right on that TP12. The bench provokes these coincidences in several ways. It follows every prefix directly with each extended code. It chains a prefix, an extended word that itself looks like a prefix, and a real prefix. It drops ce while a new word waits in pbuf at TP12. At every sampled cycle, each output is compared with pulse positions, identifiers and load values worked out from the instruction list.

// File: rtl/tpseq_pkg.sv
package tpseq_pkg;

  localparam int SS_W = 4;

  typedef enum logic [SS_W-1:0] {
    SS_XFER      = 4'd0,
    SS_CNTSKIP   = 4'd1,
    SS_IDX       = 4'd2,
    SS_EXCH      = 4'd3,
    SS_LDCOMP    = 4'd4,
    SS_STORE     = 4'd5,
    SS_ADD       = 4'd6,
    SS_AND       = 4'd7,
    SS_MUL_INIT  = 4'd8,
    SS_DIV       = 4'd9,
    SS_SUB       = 4'd10,
    SS_MUL_STEP  = 4'd11,
    SS_MUL_DONE  = 4'd12,
    SS_XUNUSED   = 4'd13
  } subseq_e;

endpackage

// File: rtl/tp_ring.sv
module tp_ring #(
  parameter int TP_N = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  output logic [TP_N-1:0] tp,
  output logic            last_tp
);

  always_ff @(posedge clk) begin
    if (rst) tp <= {{(TP_N-1){1'b0}}, 1'b1};
    else if (ce) tp <= {tp[TP_N-2:0], tp[TP_N-1]};
  end

  assign last_tp = tp[TP_N-1];

  AST_TP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(tp) == 1); // R2
  AST_TP_STEP: assert property (@(posedge clk) disable iff (rst)
    (ce && !tp[TP_N-1]) |=> (tp == ($past(tp) << 1))); // R2
  AST_TP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ce && tp[TP_N-1]) |=> tp[0]); // R2
  AST_TP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(tp)); // R3

endmodule

// File: rtl/ext_prefix_tracker.sv
module ext_prefix_tracker #(
  parameter int OP_W     = 3,
  parameter int ADDR_W   = 12,
  parameter int EXT_ADDR = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic [OP_W-1:0]   cur_op,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              ext_flag,
  output logic              prefix_now
);

  assign prefix_now = !ext_flag && (cur_op == '0) &&
                      (cur_addr == ADDR_W'(EXT_ADDR));

  always_ff @(posedge clk) begin
    if (rst) ext_flag <= 1'b0;
    else if (boundary) ext_flag <= prefix_now;
  end

  AST_EXT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (boundary && ext_flag) |=> !ext_flag); // R9
  AST_EXT_ARMS: assert property (@(posedge clk) disable iff (rst)
    (boundary && !ext_flag && cur_op == '0 && cur_addr == ADDR_W'(EXT_ADDR))
      |=> ext_flag); // R6
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(ext_flag)); // R9

endmodule

// File: rtl/subseq_select.sv
module subseq_select
  import tpseq_pkg::*;
#(
  parameter int OP_W      = 3,
  parameter int MP_REPEAT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic [OP_W-1:0] new_op,
  input  logic            new_ext,
  input  subseq_e         cur_ss,
  output subseq_e         next_ss,
  output logic            ss_last
);

  localparam int CNT_W = $clog2(MP_REPEAT + 1);

  logic [CNT_W-1:0] step_cnt;
  subseq_e          first_ss;

  always_comb begin
    if (!new_ext) begin
      first_ss = subseq_e'({{(SS_W-OP_W){1'b0}}, new_op});
    end else begin
      unique case (new_op)
        OP_W'(0): first_ss = SS_MUL_INIT;
        OP_W'(1): first_ss = SS_DIV;
        OP_W'(2): first_ss = SS_SUB;
        default:  first_ss = SS_XUNUSED;
      endcase
    end
  end

  assign ss_last = !(cur_ss == SS_MUL_INIT || cur_ss == SS_MUL_STEP);

  always_comb begin
    if (ss_last)                  next_ss = first_ss;
    else if (cur_ss == SS_MUL_INIT) next_ss = SS_MUL_STEP;
    else if (step_cnt == CNT_W'(MP_REPEAT - 1)) next_ss = SS_MUL_DONE;
    else                          next_ss = SS_MUL_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) step_cnt <= '0;
    else if (advance) begin
      if (next_ss == SS_MUL_INIT) step_cnt <= '0;
      else if (cur_ss == SS_MUL_STEP) step_cnt <= step_cnt + 1'b1;
    end
  end

  AST_MUL_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cur_ss == SS_MUL_INIT) |-> (step_cnt == '0)); // R7
  AST_MUL_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
    (cur_ss == SS_MUL_DONE) |-> (step_cnt == CNT_W'(MP_REPEAT))); // R7
  AST_MUL_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cur_ss == SS_MUL_STEP) |-> (step_cnt < CNT_W'(MP_REPEAT))); // R7

endmodule

// File: rtl/tp_sequencer.sv
module tp_sequencer
  import tpseq_pkg::*;
#(
  parameter int OP_W      = 3,
  parameter int ADDR_W    = 12,
  parameter int TP_N      = 12,
  parameter int MP_REPEAT = 6,
  parameter int EXT_ADDR  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce,
  input  logic [OP_W+ADDR_W-1:0] pbuf,
  output logic [OP_W-1:0]        seq_reg,
  output logic [ADDR_W-1:0]      addr_reg,
  output logic [SS_W-1:0]        subseq,
  output logic [TP_N-1:0]        tp,
  output logic                   eoi
);

  localparam int WORD_W = OP_W + ADDR_W;

  subseq_e cur_ss;
  subseq_e next_ss;
  logic    last_tp;
  logic    ss_last;
  logic    boundary;
  logic    ext_flag;
  logic    prefix_now;

  tp_ring #(.TP_N(TP_N)) u_ring (
    .clk(clk), .rst(rst), .ce(ce), .tp(tp), .last_tp(last_tp)
  );

  assign boundary = ce && last_tp && ss_last;

  ext_prefix_tracker #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .EXT_ADDR(EXT_ADDR)
  ) u_ext (
    .clk(clk), .rst(rst), .boundary(boundary),
    .cur_op(seq_reg), .cur_addr(addr_reg),
    .ext_flag(ext_flag), .prefix_now(prefix_now)
  );

  subseq_select #(.OP_W(OP_W), .MP_REPEAT(MP_REPEAT)) u_sel (
    .clk(clk), .rst(rst), .advance(ce && last_tp),
    .new_op(pbuf[WORD_W-1:ADDR_W]), .new_ext(prefix_now),
    .cur_ss(cur_ss), .next_ss(next_ss), .ss_last(ss_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_reg  <= '0;
      addr_reg <= '0;
    end else if (boundary) begin
      seq_reg  <= pbuf[WORD_W-1:ADDR_W];
      addr_reg <= pbuf[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_ss <= SS_XFER;
    else if (ce && last_tp) cur_ss <= next_ss;
  end

  // strobe is registered: raised on the edge entering the final pulse
  always_ff @(posedge clk) begin
    if (rst) eoi <= 1'b0;
    else if (ce) eoi <= tp[TP_N-2] && ss_last;
  end

  assign subseq = cur_ss;

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (seq_reg == $past(pbuf[WORD_W-1:ADDR_W]) &&
                  addr_reg == $past(pbuf[ADDR_W-1:0]))); // R4
  AST_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(seq_reg) && $stable(addr_reg))); // R4
  AST_EOI_ONLY_TP12: assert property (@(posedge clk) disable iff (rst)
    eoi |-> (tp[TP_N-1] && ss_last)); // R10
  AST_EOI_PRESENT: assert property (@(posedge clk) disable iff (rst)
    (tp[TP_N-1] && ss_last) |-> eoi); // R10
  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(subseq) && $stable(eoi))); // R3
  AST_SS_STABLE_MID: assert property (@(posedge clk) disable iff (rst)
    !last_tp |=> $stable(subseq)); // R2

endmodule

// File: tb/tp_sequencer_bench.sv
module tp_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic [14:0] pbuf = '0;
  logic [2:0]  seq_reg;
  logic [11:0] addr_reg;
  logic [3:0]  subseq;
  logic [11:0] tp;
  logic        eoi;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tp_sequencer u_tp_sequencer (
    .clk(clk), .rst(rst), .ce(ce), .pbuf(pbuf),
    .seq_reg(seq_reg), .addr_reg(addr_reg), .subseq(subseq),
    .tp(tp), .eoi(eoi)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit en);
    ce = en;
    @(negedge clk);
  endtask

  function automatic logic [14:0] mkw(input int op, input int addr);
    return {3'(op), 12'(addr)};
  endfunction

  // Runs the instruction now loaded; hands over nxt at its final edge.
  task automatic run_cur(input logic [14:0] cw, input bit ext,
                         input logic [14:0] nxt, input int idx);
    int op = int'(cw[14:12]);
    bit mul = ext && (op == 0);
    int nsub = mul ? 8 : 1;
    int id;
    for (int s = 0; s < nsub; s++) begin
      if (mul) id = (s == 0) ? 8 : ((s <= 6) ? 11 : 12);
      else if (!ext) id = op;                      // R5
      else id = (op == 1) ? 9 : ((op == 2) ? 10 : 13); // R8
      for (int p = 0; p < 12; p++) begin
        bit lst = (s == nsub - 1) && (p == 11);
        chk(tp == 12'(1 << p), "R2 tp position", int'(tp), 1 << p);
        chk(subseq == 4'(id), mul ? "R7 multiply subsequence" :
            (ext ? "R8 extended subsequence" : "R5 basic subsequence"),
            int'(subseq), id);
        chk(eoi == lst, "R10 eoi", int'(eoi), int'(lst));
        chk(seq_reg == cw[14:12] && addr_reg == cw[11:0], "R4 held word",
            int'({seq_reg, addr_reg}), int'(cw));
        if (lst) pbuf = nxt;
        if ((s == 0 && p == 5) || (lst && (idx % 3 == 0))) begin
          tick(1'b0);
          chk(tp == 12'(1 << p) && subseq == 4'(id), "R3 hold tp/subseq",
              int'(tp), 1 << p);
          chk(eoi == lst, "R3 hold eoi", int'(eoi), int'(lst));
          chk(seq_reg == cw[14:12] && addr_reg == cw[11:0], "R3 hold word",
              int'({seq_reg, addr_reg}), int'(cw));
        end
        tick(1'b1);
      end
    end
    chk(seq_reg == nxt[14:12] && addr_reg == nxt[11:0], "R4 load word",
        int'({seq_reg, addr_reg}), int'(nxt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [14:0] words [0:31];
    int n = 0;
    logic [14:0] cw;
    bit cext;
    bit next_ext;
    for (int op = 0; op < 8; op++) begin
      words[n] = mkw(op, (op * 291 + 5) & 12'hfff);
      n++;
    end
    for (int e = 0; e < 8; e++) begin
      words[n] = mkw(0, 6); n++;             // R6 prefix
      words[n] = mkw(e, 100 + e); n++;
    end
    words[n] = mkw(0, 6); n++;
    words[n] = mkw(0, 6); n++;               // extended: multiply, no new prefix (R9)
    words[n] = mkw(0, 6); n++;               // basic again: a real prefix
    words[n] = mkw(2, 12'h7ff); n++;
    words[n] = mkw(7, 12'hfff); n++;

    ce = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, sampled before any enabled advance after reset
    chk(tp == 12'd1, "R1 tp", int'(tp), 1);
    chk(subseq == 4'd0, "R1 subseq", int'(subseq), 0);
    chk(seq_reg == 3'd0 && addr_reg == 12'd0, "R1 word",
        int'({seq_reg, addr_reg}), 0);
    chk(eoi == 1'b0, "R1 eoi", int'(eoi), 0);

    cw = '0;
    cext = 1'b0;
    for (int i = 0; i < n; i++) begin
      run_cur(cw, cext, words[i], i);
      next_ext = !cext && (cw[14:12] == 3'd0) && (cw[11:0] == 12'd6);
      cw = words[i];
      cext = next_ext;
    end
    run_cur(cw, cext, '0, n);
    // R9: after the chain, a zero word must run as a basic transfer
    chk(subseq == 4'd0, "R9 flag cleared", int'(subseq), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule